// File: doc/BRIEF.md
# Dual-Mode SIMD Vector and Reduction Adder

This block is an integer adder array for a neural-network processing element. It works on `M*N` lanes of `W` bits each. The lanes are arranged as `N` groups, and each group holds `M` consecutive lanes. Lane `i` sits at bits `[i*W +: W]` of each flat bus. Group `g` covers lanes `g*M` through `g*M+M-1`.

The block has two modes:

- **Vector mode:** the block adds two operand vectors lane by lane. The lane sums appear on a wide vector output.
- **Reduction mode:** the block sums the `M` lanes of each group of operand A. The `N` group sums appear on a separate narrow output, with group `g` at bits `[g*W +: W]`.

All arithmetic is two's-complement and wraps modulo `2^W`. Results are the same width as the inputs.

The mode is held in a sticky internal register. Software-side control pulses `cfg_we` only when the mode changes. A `cfg_mode` value of 0 selects vector mode and 1 selects reduction mode.

Operands enter through a valid/ready handshake. A beat is accepted when `in_valid` and `in_ready` are both high. Each output is a registered valid/ready stream. Back-pressure works as follows:

- When the active output holds a result whose `*_ready` is low, that output keeps its valid and data unchanged.
- In that case `in_ready` falls, so no beat is lost.
- When no output is stalled, `in_ready` is high and a beat can be accepted every cycle.

Top module: `simd_dual_adder`

## Requirements
- R1: While `rst_n` is low and after reset, the mode is vector (0), `vec_valid` and `red_valid` are low, and `in_ready` is high.
- R2: In vector mode, an accepted beat produces `vec_data` lane `i` equal to `(in_a[i]+in_b[i]) mod 2^W` in the cycle after acceptance, with `vec_valid` high.
- R3: In reduction mode, an accepted beat produces `red_data[g*W +: W]` equal to the wrapped sum of `in_a` lanes `g*M` through `g*M+M-1` in the cycle after acceptance. `in_b` has no effect on this result.
- R4: `vec_valid` and `red_valid` are never high together. A beat raises only the valid of the mode in force when it was accepted.
- R5: A high `cfg_we` loads `cfg_mode` (0 vector, 1 reduction) into the mode register. While `cfg_we` is low, the mode is kept.
- R6: A beat accepted in the same cycle as a mode write is processed in the old mode. The new mode applies from the next cycle.
- R7: While an output is valid and its ready is low, its valid and data stay unchanged and `in_ready` is low.
- R8: When no output is stalled, `in_ready` is high. Back-to-back beats are accepted once per cycle.
- R9: Lane `i` occupies bits `[i*W +: W]` of `in_a`, `in_b` and `vec_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 1 | Mode to write: 0 vector, 1 reduction |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Operand beat can be accepted |
| in_a | input | M*N*W | Operand A, lane i at bits i*W |
| in_b | input | M*N*W | Operand B, used in vector mode only |
| vec_valid | output | 1 | Vector result valid |
| vec_ready | input | 1 | Vector result consumer ready |
| vec_data | output | M*N*W | Lane-wise sums |
| red_valid | output | 1 | Reduction result valid |
| red_ready | input | 1 | Reduction result consumer ready |
| red_data | output | N*W | Group sums, group g at bits g*W |

## Verification
Every result is due exactly one clock edge after its beat is accepted. A stalled result then stays in place until the edge at which its ready is seen high. A mode write takes effect at the same edge that captures the beat beside it, yet that beat still uses the previous mode.

The bench drives inputs on the falling edge and recomputes the expected `in_ready` from the model one time step later. It advances its model by one accepted beat per rising edge. Valid flags and data are compared at the following falling edge, so each result is checked in the cycle it is due and in every stalled cycle after that.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic {
    MODE_VEC = 1'b0,
    MODE_RED = 1'b1
  } add_mode_e;
endpackage

// File: rtl/sda_mode_reg.sv
module sda_mode_reg
  import simd_add_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic      wmode,
  output add_mode_e mode
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mode <= MODE_VEC;
    else if (we) mode <= add_mode_e'(wmode);
  end
endmodule

// File: rtl/sda_lane_array.sv
module sda_lane_array #(
  parameter int W     = 8,
  parameter int LANES = 8
) (
  input  logic [LANES*W-1:0] a,
  input  logic [LANES*W-1:0] b,
  output logic [LANES*W-1:0] sum
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sum[i*W +: W] = a[i*W +: W] + b[i*W +: W];
  end
endmodule

// File: rtl/sda_group_tree.sv
module sda_group_tree #(
  parameter int W = 8,
  parameter int M = 4
) (
  input  logic [M*W-1:0] grp,
  output logic [W-1:0]   sum
);
  localparam int LV = (M > 1) ? $clog2(M) : 0;
  localparam int P  = 1 << LV;
  localparam int NODES = 2 * P - 1;

  logic [W-1:0] node [NODES];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < M) begin : g_real
      assign node[P-1+j] = grp[j*W +: W];
    end else begin : g_pad
      assign node[P-1+j] = '0;
    end
  end

  for (genvar i = 0; i < P - 1; i++) begin : g_node
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/sda_out_stage.sv
module sda_out_stage
  import simd_add_pkg::*;
#(
  parameter int W = 8,
  parameter int M = 4,
  parameter int N = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  add_mode_e      mode,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [M*N*W-1:0] vsum,
  input  logic [N*W-1:0]   rsum,
  output logic           vec_valid,
  input  logic           vec_ready,
  output logic [M*N*W-1:0] vec_data,
  output logic           red_valid,
  input  logic           red_ready,
  output logic [N*W-1:0]   red_data
);
  logic vec_stall, red_stall, fire;

  assign vec_stall = vec_valid & ~vec_ready;
  assign red_stall = red_valid & ~red_ready;
  assign in_ready  = ~vec_stall & ~red_stall;
  assign fire      = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      red_valid <= 1'b0;
      vec_data  <= '0;
      red_data  <= '0;
    end else if (fire) begin
      vec_valid <= (mode == MODE_VEC);
      red_valid <= (mode == MODE_RED);
      if (mode == MODE_VEC) vec_data <= vsum;
      else                  red_data <= rsum;
    end else begin
      if (vec_ready) vec_valid <= 1'b0;
      if (red_ready) red_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_dual_adder.sv
module simd_dual_adder
  import simd_add_pkg::*;
#(
  parameter int W = 8,
  parameter int M = 4,
  parameter int N = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [M*N*W-1:0]   in_a,
  input  logic [M*N*W-1:0]   in_b,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [M*N*W-1:0]   vec_data,
  output logic               red_valid,
  input  logic               red_ready,
  output logic [N*W-1:0]     red_data
);
  localparam int LANES = M * N;

  add_mode_e            mode_q;
  logic [LANES*W-1:0]   vsum;
  logic [N*W-1:0]       rsum;

  sda_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wmode (cfg_mode),
    .mode  (mode_q)
  );

  sda_lane_array #(.W(W), .LANES(LANES)) u_lanes (
    .a   (in_a),
    .b   (in_b),
    .sum (vsum)
  );

  for (genvar g = 0; g < N; g++) begin : g_grp
    sda_group_tree #(.W(W), .M(M)) u_tree (
      .grp (in_a[g*M*W +: M*W]),
      .sum (rsum[g*W +: W])
    );
  end

  sda_out_stage #(.W(W), .M(M), .N(N)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .vsum      (vsum),
    .rsum      (rsum),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .vec_data  (vec_data),
    .red_valid (red_valid),
    .red_ready (red_ready),
    .red_data  (red_data)
  );
endmodule

// File: rtl/sda_checker.sv
module sda_checker #(
  parameter int W = 8,
  parameter int M = 4,
  parameter int N = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_mode,
  input logic             mode_q,
  input logic             in_valid,
  input logic             in_ready,
  input logic [M*N*W-1:0] in_a,
  input logic [M*N*W-1:0] in_b,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [M*N*W-1:0] vec_data,
  input logic             red_valid,
  input logic             red_ready,
  input logic [N*W-1:0]   red_data
);
  logic         fire;
  logic [W-1:0] lane0_sum;
  logic [W-1:0] grp0_sum;

  assign fire      = in_valid & in_ready;
  assign lane0_sum = in_a[W-1:0] + in_b[W-1:0];

  always_comb begin
    grp0_sum = '0;
    for (int k = 0; k < M; k++) grp0_sum = grp0_sum + in_a[k*W +: W];
  end

  p_one_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_valid, red_valid}));

  p_vec_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_q) |=> (vec_valid && vec_data[W-1:0] == $past(lane0_sum)));

  p_red_grp0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_q) |=> (red_valid && red_data[W-1:0] == $past(grp0_sum)));

  p_mode_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q));

  p_mode_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (mode_q == $past(cfg_mode)));

  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

  p_red_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (red_valid && !red_ready) |=> (red_valid && $stable(red_data)));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_valid && !vec_ready) || (red_valid && !red_ready)) |-> !in_ready);

  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && !red_valid) |-> in_ready);
endmodule

bind simd_dual_adder sda_checker #(.W(W), .M(M), .N(N)) u_sda_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_mode  (cfg_mode),
  .mode_q    (mode_q),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready),
  .vec_data  (vec_data),
  .red_valid (red_valid),
  .red_ready (red_ready),
  .red_data  (red_data)
);

// File: tb/test_simd_dual_adder.sv
module test_simd_dual_adder;
  localparam int W = 8, M = 4, N = 2, L = M * N;

  logic           clk = 1'b0;
  logic           rst_n, cfg_we, cfg_mode, in_valid, in_ready;
  logic [L*W-1:0] in_a, in_b, vec_data;
  logic           vec_valid, vec_ready, red_valid, red_ready;
  logic [N*W-1:0] red_data;

  simd_dual_adder #(.W(W), .M(M), .N(N)) i_simd_dual_adder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
    .red_valid(red_valid), .red_ready(red_ready), .red_data(red_data));

  always #5 clk = ~clk;

  int   checks = 0, errors = 0;
  bit   done = 0;

  // reference model state
  logic         m_mode, m_vv, m_rv;
  logic [W-1:0] m_vd [L];
  logic [W-1:0] m_rd [N];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [L*W-1:0] rand_vec();
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  // compare outputs against model (called at a falling edge)
  task automatic compare_outputs();
    chk("R4 vec_valid", 64'(vec_valid), 64'(m_vv));
    chk("R4 red_valid", 64'(red_valid), 64'(m_rv));
    if (m_vv) for (int i = 0; i < L; i++)
      chk("R2 vector lane", 64'(vec_data[i*W +: W]), 64'(m_vd[i]));
    if (m_rv) for (int g = 0; g < N; g++)
      chk("R3 group sum", 64'(red_data[g*W +: W]), 64'(m_rd[g]));
  endtask

  // one cycle: check, drive, predict, advance to next falling edge
  task automatic step(input logic cw, input logic cm, input logic iv,
                      input logic [L*W-1:0] a, input logic [L*W-1:0] b,
                      input logic vr, input logic rr);
    logic exp_ready, stalled;
    compare_outputs();
    cfg_we = cw; cfg_mode = cm; in_valid = iv; in_a = a; in_b = b;
    vec_ready = vr; red_ready = rr;
    #1;
    stalled   = (m_vv && !vr) || (m_rv && !rr);
    exp_ready = !stalled;
    if (stalled) chk("R7 in_ready while stalled", 64'(in_ready), 64'(exp_ready));
    else         chk("R8 in_ready when free", 64'(in_ready), 64'(exp_ready));
    if (iv && exp_ready) begin
      m_vv = !m_mode;
      m_rv = m_mode;
      if (!m_mode) begin
        for (int i = 0; i < L; i++) m_vd[i] = a[i*W +: W] + b[i*W +: W];
      end else begin
        for (int g = 0; g < N; g++) begin
          logic [W-1:0] s;
          s = '0;
          for (int k = 0; k < M; k++) s = s + a[(g*M+k)*W +: W];
          m_rd[g] = s;
        end
      end
    end else begin
      if (vr) m_vv = 1'b0;
      if (rr) m_rv = 1'b0;
    end
    if (cw) m_mode = cm;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [L*W-1:0] a0, b0, b1;
    logic [W-1:0]   held;
    rst_n = 0; cfg_we = 0; cfg_mode = 0; in_valid = 0;
    in_a = '0; in_b = '0; vec_ready = 1; red_ready = 1;
    m_mode = 0; m_vv = 0; m_rv = 0;
    for (int i = 0; i < L; i++) m_vd[i] = '0;
    for (int g = 0; g < N; g++) m_rd[g] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 vec_valid in reset", 64'(vec_valid), 64'd0);
    chk("R1 red_valid in reset", 64'(red_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);

    // R9: lane position, R1: reset mode is vector
    a0 = '0; b0 = '0; a0[1*W +: W] = 8'd5; b0[1*W +: W] = 8'd3;
    step(0, 0, 1, a0, b0, 1, 1);
    chk("R1 default mode gives vector result", 64'(vec_valid), 64'd1);
    chk("R9 lane1 position", 64'(vec_data), 64'(L*W)'(8) << W);

    // R2 wrap-around
    a0 = '0; b0 = '0; a0[7:0] = 8'hF0; b0[7:0] = 8'h25;
    step(0, 0, 1, a0, b0, 1, 1);
    chk("R2 wrap lane0", 64'(vec_data[7:0]), 64'h15);

    // R6: mode write with data applies from next cycle
    a0 = rand_vec(); b0 = rand_vec();
    step(1, 1, 1, a0, b0, 1, 1);
    chk("R6 beat uses old mode", 64'(vec_valid), 64'd1);
    chk("R6 no reduction valid", 64'(red_valid), 64'd0);

    // R5: new mode now in force; R3: in_b has no effect
    a0 = '0; for (int i = 0; i < M; i++) a0[i*W +: W] = W'(i + 1);
    b0 = rand_vec(); b1 = ~b0;
    step(0, 0, 1, a0, b0, 1, 1);
    chk("R5 reduction mode active", 64'(red_valid), 64'd1);
    chk("R3 group0 sum", 64'(red_data[W-1:0]), 64'd10);
    step(0, 0, 1, a0, b1, 1, 1);
    chk("R3 in_b ignored", 64'(red_data[W-1:0]), 64'd10);

    // R7: stall holds data and blocks input
    step(0, 0, 1, a0, b0, 1, 0);
    held = red_data[W-1:0];
    step(0, 0, 1, rand_vec(), b0, 1, 0);
    chk("R7 held data", 64'(red_data[W-1:0]), 64'(held));
    chk("R7 in_ready low", 64'(in_ready), 64'd0);
    step(0, 0, 0, a0, b0, 1, 1);

    // R8: back-to-back throughput plus random traffic
    for (int n = 0; n < 3000; n++) begin
      logic cw;
      cw = ($urandom % 16) == 0;
      step(cw, 1'($urandom), 1'($urandom % 4 != 0), rand_vec(), rand_vec(),
           1'($urandom % 4 != 0), 1'($urandom % 4 != 0));
    end
    step(0, 0, 0, '0, '0, 1, 1);
    compare_outputs();
    finish_run();
  end
endmodule